// File: doc/BRIEF.md
# GPIO Pin Resolver with Level Sense

This block sits between a GPIO register bank and the pads of a bank of general purpose pins. For every pin it takes the software output bit, a per-pin configuration word, and an external pad level that comes with its own "externally driven" flag. From these it works out whether the pin driver is on and which level it drives. It also works out the value software should see as the pin's input, and whether the internal and external drivers are fighting.

The configuration word carries a direction bit and an input-buffer disconnect bit. It also holds a pull selector, a drive-mode field and a sense selector. Some drive modes turn the driver on for only one output level. A selected pull can hold a floating pin at a level, and it then counts as driving the pin. When the input buffer is disconnected, a selected pull overrides the input value. A sense selector on each pin compares the externally driven level against high or low, and all pins feed one combined detect line.

The resolved input value, the combined detect line and a per-pin output-change strobe are registered once per clock. The pad drive signals and the short-circuit flags are combinational.

Top module: `gpio_pin_resolver`

## Requirements
- R1: The drive-mode field is configuration bits [10:8]. Codes 0 to 3 enable the driver for both output levels, codes 4 and 5 only when the output bit is 1, and codes 6 and 7 only when it is 0. The driver is on only if direction bit 0 is also 1. While the driver is on, pad_oe_o is 1 and pad_out_o equals the output bit.
- R2: The pull field is configuration bits [3:2]. Code 1 selects a pull to 0 and code 3 a pull to 1. Codes 0 and 2 select no pull.
- R3: When configuration bit 1 is 1, the input buffer is disconnected and the pad level is ignored. A selected pull then loads the pull level into the input value, and with no pull the input value holds.
- R4: When the buffer is connected, the pad is not externally driven and the driver is on, the input value takes the output bit.
- R5: When the buffer is connected, the pad is not externally driven, the driver is off and a pull is selected, pad_oe_o is 1, pad_out_o is the pull level, and the input value takes the pull level.
- R6: When the buffer is connected, the pad is not externally driven, the driver is off and no pull is selected, pad_oe_o is 0 and the input value holds.
- R7: When the buffer is connected and pad_valid_i is 1, the input value takes pad_in_i. in_value_o shows each new input value one clock after the inputs that produce it.
- R8: short_o for a pin is 1 in the same cycle exactly when the buffer is connected, pad_valid_i is 1, the driver is on, and the output bit differs from pad_in_i.
- R9: The sense field is configuration bits [17:16]. Code 2 matches pad_in_i = 1 and code 3 matches pad_in_i = 0, only on pins with a connected buffer and pad_valid_i = 1. detect_o is the OR of all matches, registered one clock later.
- R10: chg_o for a pin is 1 for one clock, one clock after pad_oe_o or pad_out_o differs from its value in the previous cycle. The stored previous values reset to 0.
- R11: While reset is active, in_value_o, detect_o and chg_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| out_bits_i | input | NUM_PINS | Software output bit per pin |
| cfg_i | input | NUM_PINS*CFG_W | Configuration word per pin, pin k at [k*CFG_W +: CFG_W] |
| pad_in_i | input | NUM_PINS | External pad level |
| pad_valid_i | input | NUM_PINS | 1 when the pad is driven externally |
| pad_out_o | output | NUM_PINS | Level presented to the pad |
| pad_oe_o | output | NUM_PINS | Pad driver enable |
| in_value_o | output | NUM_PINS | Registered resolved input value |
| short_o | output | NUM_PINS | Internal/external drive conflict per pin |
| detect_o | output | 1 | Registered combined level-sense detect |
| chg_o | output | NUM_PINS | Registered output-change strobe per pin |

## Verification
The assertions assume that every input is a known, stable level at each rising clock edge. They also assume reset is held for at least one edge, so the stored previous drive values start from a defined point. The bench changes inputs only on falling edges. It changes one pin's configuration or level per step, so each registered effect can be traced to one cause. It holds reset while the configuration inputs are set to the disconnected, no-pull word.

// File: rtl/gpio_res_pkg.sv
`timescale 1ns/1ps
package gpio_res_pkg;

    localparam int DIR_BIT    = 0;
    localparam int BUFDIS_BIT = 1;
    localparam int PULL_LSB   = 2;
    localparam int MODE_LSB   = 8;
    localparam int SENSE_LSB  = 16;
    localparam int FIELD_TOP  = SENSE_LSB + 1;

    typedef enum logic [1:0] {
        PULL_NONE  = 2'd0,
        PULL_LOW   = 2'd1,
        PULL_SPARE = 2'd2,
        PULL_HIGH  = 2'd3
    } pull_sel_e;

    typedef enum logic [1:0] {
        SENSE_IDLE0 = 2'd0,
        SENSE_IDLE1 = 2'd1,
        SENSE_HI    = 2'd2,
        SENSE_LO    = 2'd3
    } sense_sel_e;

    typedef struct packed {
        logic oe;
        logic lvl;
        logic in_upd;
        logic in_val;
        logic short_f;
        logic sense_hit;
    } pin_res_t;

    // Drive-mode gate: which output levels a mode lets through.
    function automatic logic mode_permits(input logic [2:0] mode, input logic out_bit);
        logic ok;
        case (mode)
            3'd0, 3'd1, 3'd2, 3'd3: ok = 1'b1;
            3'd4, 3'd5:             ok = out_bit;
            default:                ok = ~out_bit;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
module gpio_pin_cell
    import gpio_res_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             out_bit_i,
    input  logic             pad_in_i,
    input  logic             pad_valid_i,
    output pin_res_t         res_o
);

    localparam logic [CFG_W-1:0] USED_MASK =
        CFG_W'((32'h3 << SENSE_LSB) | (32'h7 << MODE_LSB) | (32'h3 << PULL_LSB) |
               (32'h1 << BUFDIS_BIT) | (32'h1 << DIR_BIT));

    logic       dir_en;
    logic       buf_dis;
    pull_sel_e  pull_sel;
    sense_sel_e sense_sel;
    logic [2:0] drv_mode;
    logic       pull_on;
    logic       pull_lvl;
    logic       drv_on;
    logic       cfg_unused;

    assign dir_en     = cfg_i[DIR_BIT];
    assign buf_dis    = cfg_i[BUFDIS_BIT];
    assign pull_sel   = pull_sel_e'(cfg_i[PULL_LSB +: 2]);
    assign drv_mode   = cfg_i[MODE_LSB +: 3];
    assign sense_sel  = sense_sel_e'(cfg_i[SENSE_LSB +: 2]);
    assign cfg_unused = |(cfg_i & ~USED_MASK);

    assign pull_on  = (pull_sel == PULL_LOW) || (pull_sel == PULL_HIGH);
    assign pull_lvl = (pull_sel == PULL_HIGH);
    assign drv_on   = dir_en & mode_permits(drv_mode, out_bit_i);

    always_comb begin
        res_o           = '0;
        res_o.oe        = drv_on;
        res_o.lvl       = out_bit_i;
        if (buf_dis) begin
            if (pull_on) begin
                res_o.in_upd = 1'b1;
                res_o.in_val = pull_lvl;
            end
        end else if (pad_valid_i) begin
            res_o.in_upd    = 1'b1;
            res_o.in_val    = pad_in_i;
            res_o.short_f   = drv_on & (out_bit_i != pad_in_i);
            res_o.sense_hit = ((sense_sel == SENSE_HI) &  pad_in_i) |
                              ((sense_sel == SENSE_LO) & ~pad_in_i);
        end else if (drv_on) begin
            res_o.in_upd = 1'b1;
            res_o.in_val = out_bit_i;
        end else if (pull_on) begin
            res_o.oe     = 1'b1;
            res_o.lvl    = pull_lvl;
            res_o.in_upd = 1'b1;
            res_o.in_val = pull_lvl;
        end
    end

endmodule

// File: rtl/gpio_sense_merge.sv
`timescale 1ns/1ps
module gpio_sense_merge #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] hit_i,
    output logic                any_o
);

    assign any_o = |hit_i;

endmodule

// File: rtl/gpio_pin_resolver.sv
`timescale 1ns/1ps
module gpio_pin_resolver
    import gpio_res_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CFG_W    = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_PINS-1:0]       out_bits_i,
    input  logic [NUM_PINS*CFG_W-1:0] cfg_i,
    input  logic [NUM_PINS-1:0]       pad_in_i,
    input  logic [NUM_PINS-1:0]       pad_valid_i,
    output logic [NUM_PINS-1:0]       pad_out_o,
    output logic [NUM_PINS-1:0]       pad_oe_o,
    output logic [NUM_PINS-1:0]       in_value_o,
    output logic [NUM_PINS-1:0]       short_o,
    output logic                      detect_o,
    output logic [NUM_PINS-1:0]       chg_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] in_val;
        logic [NUM_PINS-1:0] chg;
        logic [NUM_PINS-1:0] oe_prev;
        logic [NUM_PINS-1:0] lvl_prev;
        logic                detect;
        logic                armed;
    } res_state_t;

    res_state_t cur_q, nxt_d;

    logic [NUM_PINS-1:0] oe_vec, lvl_vec, upd_vec, inv_vec, short_vec, hit_vec, bufdis_vec;
    logic                any_hit;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        pin_res_t res;
        gpio_pin_cell #(.CFG_W(CFG_W)) cell_i (
            .cfg_i       (cfg_i[k*CFG_W +: CFG_W]),
            .out_bit_i   (out_bits_i[k]),
            .pad_in_i    (pad_in_i[k]),
            .pad_valid_i (pad_valid_i[k]),
            .res_o       (res)
        );
        assign oe_vec[k]     = res.oe;
        assign lvl_vec[k]    = res.lvl;
        assign upd_vec[k]    = res.in_upd;
        assign inv_vec[k]    = res.in_val;
        assign short_vec[k]  = res.short_f;
        assign hit_vec[k]    = res.sense_hit;
        assign bufdis_vec[k] = cfg_i[k*CFG_W + BUFDIS_BIT];
    end

    gpio_sense_merge #(.NUM_PINS(NUM_PINS)) merge_i (
        .hit_i (hit_vec),
        .any_o (any_hit)
    );

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.in_val   = (cur_q.in_val & ~upd_vec) | (inv_vec & upd_vec);
        nxt_d.chg      = (oe_vec ^ cur_q.oe_prev) | (lvl_vec ^ cur_q.lvl_prev);
        nxt_d.oe_prev  = oe_vec;
        nxt_d.lvl_prev = lvl_vec;
        nxt_d.detect   = any_hit;
        nxt_d.armed    = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign pad_out_o  = lvl_vec;
    assign pad_oe_o   = oe_vec;
    assign short_o    = short_vec;
    assign in_value_o = cur_q.in_val;
    assign detect_o   = cur_q.detect;
    assign chg_o      = cur_q.chg;

    // R7
    ext_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.armed |=> (((in_value_o ^ $past(pad_in_i)) & $past(pad_valid_i & ~bufdis_vec)) == '0));

    // R8
    short_drv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((short_o & ~(pad_valid_i & pad_oe_o)) == '0));

    // R9
    detect_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.armed && (pad_valid_i == '0)) |=> !detect_o);

    // R10
    chg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.armed && $stable(pad_oe_o) && $stable(pad_out_o)) |=> (chg_o == '0));

endmodule

// File: tb/gpio_pin_resolver_tb_top.sv
`timescale 1ns/1ps
module gpio_pin_resolver_tb_top;

    localparam int N  = 32;
    localparam int CW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    out_bits = '0;
    logic [N*CW-1:0] cfg = '0;
    logic [N-1:0]    pad_in = '0;
    logic [N-1:0]    pad_valid = '0;
    logic [N-1:0]    pad_out, pad_oe, in_value, short_f, chg;
    logic            detect;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_pin_resolver #(.NUM_PINS(N), .CFG_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .out_bits_i(out_bits), .cfg_i(cfg),
        .pad_in_i(pad_in), .pad_valid_i(pad_valid), .pad_out_o(pad_out),
        .pad_oe_o(pad_oe), .in_value_o(in_value), .short_o(short_f),
        .detect_o(detect), .chg_o(chg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int pin, input logic [31:0] v);
        cfg[pin*CW +: CW] = v;
    endtask

    task automatic step_reg();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) set_cfg(i, 32'h2);
        repeat (3) @(posedge clk);
        #1;
        chk("R11 in_value", in_value, 0);
        chk("R11 detect", detect, 0);
        chk("R11 chg", chg, 0);
        @(negedge clk); rst_n = 1'b1;
        step_reg();
        chk("R10 no change after reset", chg, 0);
    endtask

    task automatic t_drive();
        @(negedge clk); set_cfg(0, 32'h1); out_bits[0] = 1'b1; #1;
        chk("R1 mode0 oe", pad_oe[0], 1); chk("R1 mode0 lvl", pad_out[0], 1);
        step_reg(); chk("R4 in from out 1", in_value[0], 1);
        @(negedge clk); out_bits[0] = 1'b0; #1;
        chk("R1 mode0 oe low", pad_oe[0], 1); chk("R1 lvl low", pad_out[0], 0);
        step_reg(); chk("R4 in from out 0", in_value[0], 0);
        @(negedge clk); set_cfg(0, 32'h401); #1; chk("R1 mode4 out0 off", pad_oe[0], 0);
        step_reg(); chk("R6 hold when undriven", in_value[0], 0);
        @(negedge clk); out_bits[0] = 1'b1; #1; chk("R1 mode4 out1 on", pad_oe[0], 1);
        @(negedge clk); set_cfg(0, 32'h601); #1; chk("R1 mode6 out1 off", pad_oe[0], 0);
        @(negedge clk); out_bits[0] = 1'b0; #1; chk("R1 mode6 out0 on", pad_oe[0], 1);
        @(negedge clk); set_cfg(0, 32'h000); out_bits[0] = 1'b1; #1;
        chk("R1 dir0 off", pad_oe[0], 0);
    endtask

    task automatic t_pull();
        @(negedge clk); set_cfg(1, 32'hC); #1;
        chk("R5 pull-up oe", pad_oe[1], 1); chk("R5 pull-up lvl", pad_out[1], 1);
        step_reg(); chk("R5 pull-up in", in_value[1], 1);
        @(negedge clk); set_cfg(1, 32'h8); #1; chk("R2 code2 no pull oe", pad_oe[1], 0);
        step_reg(); chk("R6 hold 1", in_value[1], 1);
        @(negedge clk); set_cfg(1, 32'h4); #1;
        chk("R2 pull-down oe", pad_oe[1], 1); chk("R2 pull-down lvl", pad_out[1], 0);
        step_reg(); chk("R5 pull-down in", in_value[1], 0);
        @(negedge clk); set_cfg(1, 32'h0); #1; chk("R6 no pull oe", pad_oe[1], 0);
        step_reg(); chk("R6 hold 0", in_value[1], 0);
    endtask

    task automatic t_disc();
        @(negedge clk); set_cfg(2, 32'hE); pad_valid[2] = 1'b1; pad_in[2] = 1'b0;
        step_reg(); chk("R3 pull-up overrides pad", in_value[2], 1);
        @(negedge clk); set_cfg(2, 32'h6);
        step_reg(); chk("R3 pull-down overrides", in_value[2], 0);
        @(negedge clk); set_cfg(2, 32'h2); pad_in[2] = 1'b1;
        step_reg(); chk("R3 pad ignored, hold", in_value[2], 0);
        @(negedge clk); pad_valid[2] = 1'b0; pad_in[2] = 1'b0;
    endtask

    task automatic t_ext();
        @(negedge clk); set_cfg(3, 32'h0); pad_valid[3] = 1'b1; pad_in[3] = 1'b1;
        step_reg(); chk("R7 in from pad 1", in_value[3], 1);
        @(negedge clk); pad_in[3] = 1'b0;
        step_reg(); chk("R7 in from pad 0", in_value[3], 0);
        @(negedge clk); set_cfg(3, 32'h1); out_bits[3] = 1'b1; #1;
        chk("R8 conflict short", short_f[3], 1);
        @(negedge clk); pad_in[3] = 1'b1; #1; chk("R8 agree no short", short_f[3], 0);
        @(negedge clk); pad_in[3] = 1'b0; set_cfg(3, 32'h3); #1;
        chk("R8 buffer off no short", short_f[3], 0);
        @(negedge clk); set_cfg(3, 32'h1); pad_valid[3] = 1'b0; #1;
        chk("R8 no ext no short", short_f[3], 0);
        @(negedge clk); set_cfg(3, 32'h0); out_bits[3] = 1'b0;
    endtask

    task automatic t_sense();
        @(negedge clk); set_cfg(4, 32'h20000); pad_valid[4] = 1'b1; pad_in[4] = 1'b1;
        step_reg(); chk("R9 sense high hit", detect, 1);
        @(negedge clk); pad_in[4] = 1'b0;
        step_reg(); chk("R9 sense high miss", detect, 0);
        @(negedge clk); set_cfg(4, 32'h30000);
        step_reg(); chk("R9 sense low hit", detect, 1);
        @(negedge clk); set_cfg(4, 32'h30002);
        step_reg(); chk("R9 buffer off no sense", detect, 0);
        @(negedge clk); set_cfg(4, 32'h30000); pad_valid[4] = 1'b0;
        step_reg(); chk("R9 not external no sense", detect, 0);
        @(negedge clk); set_cfg(4, 32'h20000); pad_valid[4] = 1'b1;
        set_cfg(20, 32'h30000); pad_valid[20] = 1'b1; pad_in[20] = 1'b0;
        step_reg(); chk("R9 OR over pins", detect, 1);
        @(negedge clk); pad_valid = '0; pad_in = '0; set_cfg(4, 32'h2); set_cfg(20, 32'h2);
    endtask

    task automatic t_chg();
        @(negedge clk); set_cfg(5, 32'h2); out_bits[5] = 1'b0;
        step_reg(); step_reg();
        chk("R10 steady no strobe", chg[5], 0);
        @(negedge clk); out_bits[5] = 1'b1;
        step_reg(); chk("R10 level change strobe", chg[5], 1);
        step_reg(); chk("R10 one-cycle strobe", chg[5], 0);
        @(negedge clk); set_cfg(5, 32'h3);
        step_reg(); chk("R10 enable change strobe", chg[5], 1);
        step_reg(); chk("R10 strobe clears", chg[5], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_drive();
        t_pull();
        t_disc();
        t_ext();
        t_sense();
        t_chg();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule